// File: doc/BRIEF.md
# Strap-Selected Serial Register Chain Loader

This block loads the nine-register control bank of an audio front end without any bus protocol. When the stand-alone strap is high and the run strap is also high, the 68 stored control bits form a single shift chain. Each falling edge of the serial clock line moves the chain one place and takes a new bit from the serial data line. The last chain stage drives the voice-activity output pin, so the old contents appear on that pin while a new image is shifted in.

While the stand-alone strap is high, the bank presents a fixed default image to the rest of the chip. That image has only a few bits set, its power-down bit is the inverse of the run strap, and tone generation is held off. When the stand-alone strap goes low, the shifted-in contents become the live configuration. The register-write port of the bus engine then owns the bank again, and the companion power-down pin is driven from a stored bit.

All four strap and serial inputs are asynchronous to the system clock. They pass through a two-stage synchronizer, and the serial clock is edge-detected in the system clock domain before any shift takes place.

Top module: `strap_chain_loader`

## Requirements
- R1: The chain shifts only on a falling edge of `ser_clk` that is seen while both `strap_alone` and `strap_run` are high. A rising edge never shifts the chain.
- R2: The bit on `ser_dat` just before the falling edge enters register 0 bit 0. Registers 0 and 1 take part with bits 0..5 only, so R0 bit 5 feeds R1 bit 0 and R1 bit 5 feeds R2 bit 0. For registers 2..8, bit 7 of one register feeds bit 0 of the next. Register r bit b appears at `cfg_o[8*r+b]`.
- R3: After exactly 68 falling edges, the first bit shifted in sits in R8 bit 7, and the whole bank holds the shifted image.
- R4: `vox_o` always equals R8 bit 7 of the stored chain. While a new image is loaded, the previous image therefore leaves on `vox_o` in chain order.
- R5: Bits 6 and 7 of R0 and R1 are not storage. They read 0 on `cfg_o` whatever was shifted in or written.
- R6: While the synchronized `strap_alone` is high, `cfg_o` is zero except for bits 0, 1 and 10. Bit 50 (R6 bit 2, power-down) equals the inverse of `strap_run`, and `pdn_o` follows it.
- R7: `tone_en_o` is low while the synchronized `strap_alone` is high and high otherwise.
- R8: While `strap_alone` is low, `cfg_o` shows the stored bank. A one-cycle `bus_we` loads `bus_data` into register `bus_addr`; for R0 and R1 only data bits 5..0 are used. Writes to an address of 9 or more, and writes made while `strap_alone` is high, change nothing.
- R9: `hpdn_oe_o` is high only while `strap_alone` is low, and `hpdn_drive_o` equals stored R5 bit 1.
- R10: Falling edges on `ser_clk` while `strap_run` is low leave the chain unchanged.
- R11: During reset the synchronized straps read low, so `tone_en_o` and `hpdn_oe_o` are high even with `strap_alone` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of synchronizer and edge-detect flops |
| strap_alone | input | 1 | Stand-alone strap, asynchronous |
| strap_run | input | 1 | Run strap: high normal, low power-down; asynchronous |
| ser_clk | input | 1 | Serial shift clock line, asynchronous |
| ser_dat | input | 1 | Serial data line, asynchronous |
| bus_we | input | 1 | Register write strobe from the bus engine |
| bus_addr | input | 4 | Register index for a bus write |
| bus_data | input | 8 | Register data for a bus write |
| cfg_o | output | 72 | Effective register bank, register r at bits 8r+7..8r |
| vox_o | output | 1 | Chain tail, R8 bit 7 |
| pdn_o | output | 1 | Effective power-down bit |
| tone_en_o | output | 1 | Tone generation permitted |
| hpdn_oe_o | output | 1 | Drive enable for the power-down pin |
| hpdn_drive_o | output | 1 | Value to drive on the power-down pin |

## Verification
The assertions assume that `bus_we` comes from logic in the system clock domain. They also assume that each `ser_clk` level and each `ser_dat` value lasts longer than the synchronizer depth, so that every falling edge yields exactly one shift pulse with a settled data bit. The bench drives every serial level for four system clocks and changes data only while the serial clock is low. It keeps `strap_run` at one level across each load, so no edge is lost or doubled.

// File: rtl/chl_pkg.sv
// Package: shared sizes, the chain/register mapping functions and the
// fixed stand-alone image. Assumes register 0..NARROW_CNT-1 are the only
// registers with shortened chain membership.
package chl_pkg;
    parameter int NREG       = 9;
    parameter int REGW       = 8;
    parameter int NARROW_CNT = 2;
    parameter int NARROW_W   = 6;

    localparam int CFG_W     = NREG * REGW;
    localparam int CHAIN_LEN = NARROW_CNT * NARROW_W + (NREG - NARROW_CNT) * REGW;
    localparam int AW        = 4;
    localparam int PDN_POS   = 6 * REGW + 2;
    localparam int HPDN_POS  = 5 * REGW + 1;

    // Number of chain stages owned by register r.
    function automatic int reg_width(int r);
        return (r < NARROW_CNT) ? NARROW_W : REGW;
    endfunction

    // Chain index of bit 0 of register r.
    function automatic int reg_base(int r);
        int s;
        s = 0;
        for (int i = 0; i < r; i++) s += reg_width(i);
        return s;
    endfunction

    // Bank bit position held by chain stage k.
    function automatic int chain_to_cfg(int k);
        for (int r = 0; r < NREG; r++) begin
            if (k < reg_base(r) + reg_width(r))
                return r * REGW + (k - reg_base(r));
        end
        return 0;
    endfunction

    // Chain stage holding bank bit c, or -1 for a bit outside the chain.
    function automatic int cfg_to_chain(int c);
        int r;
        int b;
        r = c / REGW;
        b = c % REGW;
        if (b < reg_width(r)) return reg_base(r) + b;
        return -1;
    endfunction

    // Bank image presented in stand-alone operation (power-down bit excluded).
    function automatic logic [CFG_W-1:0] default_image();
        logic [CFG_W-1:0] v;
        v = '0;
        v[0]        = 1'b1;
        v[1]        = 1'b1;
        v[REGW + 2] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/chl_sync.sv
// Multi-bit level synchronizer. Assumes each bit is an independent
// asynchronous level; resets every stage low.
module chl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift asynchronous inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/chl_fall_detect.sv
// Falling-edge detector for a synchronized serial clock, with the data
// line delayed by one stage so the bit returned is the one present
// just before the edge. Assumes both inputs are already synchronized.
module chl_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic data_i,
    output logic fall_o,
    output logic data_o
);
    logic line_d;
    logic data_d;

    // Hold the previous line and data samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_d <= 1'b0;
            data_d <= 1'b0;
        end else begin
            line_d <= line_i;
            data_d <= data_i;
        end
    end

    assign fall_o = line_d & ~line_i;
    assign data_o = data_d;
endmodule

// File: rtl/chl_shift_chain.sv
// Storage of the bank as a linear shift chain. Stage 0 takes the serial
// bit; each stage also accepts a parallel write routed from its bank
// position. Assumes shift_en and wr_en are never high together. Stages
// carry no reset: their value is unknown until loaded.
module chl_shift_chain
    import chl_pkg::*;
#(
    parameter int LEN   = CHAIN_LEN,
    parameter int DW    = REGW,
    parameter int ADDRW = AW
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             shift_bit,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [LEN-1:0]   chain_q
);
    logic [LEN-1:0] feed;

    assign feed = {chain_q[LEN-2:0], shift_bit};

    for (genvar k = 0; k < LEN; k++) begin : g_stage
        localparam int             CPOS = chain_to_cfg(k);
        localparam logic [ADDRW-1:0] RSEL = ADDRW'(CPOS / DW);
        localparam int             BSEL = CPOS % DW;

        // Advance, overwrite, or hold one chain stage.
        always_ff @(posedge clk) begin
            if (shift_en)
                chain_q[k] <= feed[k];
            else if (wr_en && (wr_addr == RSEL))
                chain_q[k] <= wr_data[BSEL];
        end
    end
endmodule

// File: rtl/chl_cfg_select.sv
// Builds the register-bank view of the chain and chooses between it and
// the fixed stand-alone image. Also derives the tone permit and the
// power-down pin controls. Assumes strap levels are synchronized.
module chl_cfg_select
    import chl_pkg::*;
#(
    parameter int LEN = CHAIN_LEN,
    parameter int CW  = CFG_W
) (
    input  logic [LEN-1:0] chain_q,
    input  logic           alone_s,
    input  logic           run_s,
    output logic [CW-1:0]  cfg_o,
    output logic           pdn_o,
    output logic           tone_en_o,
    output logic           hpdn_oe_o,
    output logic           hpdn_drive_o
);
    localparam logic [CW-1:0] DEF_IMG = default_image();

    logic [CW-1:0] img;

    for (genvar c = 0; c < CW; c++) begin : g_bit
        localparam int CI = cfg_to_chain(c);
        if (CI >= 0) begin : g_live
            assign img[c] = chain_q[CI];
        end else begin : g_tied
            assign img[c] = 1'b0;
        end
    end

    // Select the stored bank or the fixed image with strap power-down.
    always_comb begin
        if (alone_s) begin
            cfg_o          = DEF_IMG;
            cfg_o[PDN_POS] = ~run_s;
        end else begin
            cfg_o = img;
        end
    end

    assign pdn_o        = cfg_o[PDN_POS];
    assign tone_en_o    = ~alone_s;
    assign hpdn_oe_o    = ~alone_s;
    assign hpdn_drive_o = img[HPDN_POS];
endmodule

// File: rtl/strap_chain_loader.sv
// Top: strap-selected serial loader for the control bank. Synchronizes
// the straps and serial lines, turns serial-clock falling edges into
// shift pulses, and gates bus writes off in stand-alone operation.
// Assumes bus_we is synchronous to clk.
module strap_chain_loader
    import chl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_alone,
    input  logic             strap_run,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [REGW-1:0]  bus_data,
    output logic [CFG_W-1:0] cfg_o,
    output logic             vox_o,
    output logic             pdn_o,
    output logic             tone_en_o,
    output logic             hpdn_oe_o,
    output logic             hpdn_drive_o
);
    logic [3:0]           sync_q;
    logic                 alone_s;
    logic                 run_s;
    logic                 sclk_s;
    logic                 sdat_s;
    logic                 fall;
    logic                 shift_bit;
    logic                 shift_en;
    logic                 wr_gate;
    logic [CHAIN_LEN-1:0] chain_q;

    chl_sync #(.W(4), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({strap_alone, strap_run, ser_clk, ser_dat}),
        .q_o   (sync_q)
    );

    assign alone_s = sync_q[3];
    assign run_s   = sync_q[2];
    assign sclk_s  = sync_q[1];
    assign sdat_s  = sync_q[0];

    chl_fall_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sclk_s),
        .data_i (sdat_s),
        .fall_o (fall),
        .data_o (shift_bit)
    );

    assign shift_en = fall & alone_s & run_s;
    assign wr_gate  = bus_we & ~alone_s;

    chl_shift_chain u_chain (
        .clk       (clk),
        .shift_en  (shift_en),
        .shift_bit (shift_bit),
        .wr_en     (wr_gate),
        .wr_addr   (bus_addr),
        .wr_data   (bus_data),
        .chain_q   (chain_q)
    );

    chl_cfg_select u_sel (
        .chain_q      (chain_q),
        .alone_s      (alone_s),
        .run_s        (run_s),
        .cfg_o        (cfg_o),
        .pdn_o        (pdn_o),
        .tone_en_o    (tone_en_o),
        .hpdn_oe_o    (hpdn_oe_o),
        .hpdn_drive_o (hpdn_drive_o)
    );

    assign vox_o = chain_q[CHAIN_LEN-1];
endmodule

// File: rtl/chain_loader_checker.sv
// Checker for strap_chain_loader: temporal rules on shifting, writes and
// the stand-alone outputs. Attached by the bind at the end of this file.
module chain_loader_checker
    import chl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alone_s,
    input logic                 run_s,
    input logic                 shift_en,
    input logic                 shift_bit,
    input logic                 wr_gate,
    input logic                 bus_we,
    input logic [CHAIN_LEN-1:0] chain_q,
    input logic                 vox_o,
    input logic [CFG_W-1:0]     cfg_o,
    input logic                 tone_en_o,
    input logic                 hpdn_oe_o
);
    // R1, R10: without both straps and without a write the chain holds.
    assert_hold_without_straps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(alone_s && run_s) && !wr_gate) |=> $stable(chain_q));

    assert_entry_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (chain_q[0] == $past(shift_bit)));

    assert_tail_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (vox_o == $past(chain_q[CHAIN_LEN-2])));

    assert_default_image_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alone_s |-> (cfg_o[0] && cfg_o[1] && ($countones(cfg_o) <= 4)));

    assert_tone_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alone_s |-> !tone_en_o);

    assert_bus_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && alone_s && !shift_en) |=> $stable(chain_q));

    assert_pin_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alone_s |-> !hpdn_oe_o);
endmodule

bind strap_chain_loader chain_loader_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alone_s   (alone_s),
    .run_s     (run_s),
    .shift_en  (shift_en),
    .shift_bit (shift_bit),
    .wr_gate   (wr_gate),
    .bus_we    (bus_we),
    .chain_q   (chain_q),
    .vox_o     (vox_o),
    .cfg_o     (cfg_o),
    .tone_en_o (tone_en_o),
    .hpdn_oe_o (hpdn_oe_o)
);

// File: tb/sim_strap_chain_loader.sv
module sim_strap_chain_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alone = 1'b0;
    logic        strap_run = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic [71:0] cfg_o;
    logic        vox_o, pdn_o, tone_en_o, hpdn_oe_o, hpdn_drive_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    strap_chain_loader u0 (
        .clk(clk), .rst_n(rst_n), .strap_alone(strap_alone), .strap_run(strap_run),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_data(bus_data), .cfg_o(cfg_o), .vox_o(vox_o), .pdn_o(pdn_o),
        .tone_en_o(tone_en_o), .hpdn_oe_o(hpdn_oe_o), .hpdn_drive_o(hpdn_drive_o)
    );

    // Stimulus images and the bank each should read back as (R5: R0/R1 bits 7:6 zero).
    localparam logic [71:0] STIM [4] = '{
        72'hFF_FFFF_FFFF_FFFF_FFFF,
        72'h00_0000_0000_0000_0000,
        72'hA5_5A3C_C30F_F096_6981,
        72'h80_0000_0000_0000_0001
    };
    localparam logic [71:0] EXPV [4] = '{
        72'hFF_FFFF_FFFF_FFFF_3F3F,
        72'h00_0000_0000_0000_0000,
        72'hA5_5A3C_C30F_F096_2901,
        72'h80_0000_0000_0000_0001
    };
    localparam logic [71:0] DEF_RUN  = 72'h00_0000_0000_0000_0403;
    localparam logic [71:0] DEF_PDN  = 72'h00_0004_0000_0000_0403;

    // Bank position of chain stage k, from R2.
    function automatic int stage_pos(int k);
        if (k < 6)  return k;
        if (k < 12) return 8 + (k - 6);
        return 16 + (k - 12);
    endfunction

    task automatic check(input logic [71:0] act, input logic [71:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Shift one 68-bit image in; returns how many tail bits disagreed with old.
    task automatic load_image(input logic [71:0] img, input logic [71:0] old, output int miss);
        miss = 0;
        for (int j = 0; j < 68; j++) begin
            ser_dat = img[stage_pos(67 - j)];
            wait_n(4);
            ser_clk = 1'b1;
            wait_n(4);
            if (vox_o !== old[stage_pos(67 - j)]) miss++;
            ser_clk = 1'b0;
            wait_n(4);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        wait_n(1);
    endtask

    initial begin
        logic [71:0] prev;
        logic [71:0] snap;
        int miss;
        // R11: straps high during reset still read low.
        strap_alone = 1'b1; strap_run = 1'b1;
        wait_n(5);
        check(72'(tone_en_o), 72'(1), "R11 tone_en in reset");
        check(72'(hpdn_oe_o), 72'(1), "R11 hpdn_oe in reset");
        rst_n = 1'b1;
        wait_n(4);
        check(cfg_o, DEF_RUN, "R6 default image run");
        check(72'(pdn_o), 72'(0), "R6 pdn with run high");
        check(72'(tone_en_o), 72'(0), "R7 tone off stand-alone");
        check(72'(hpdn_oe_o), 72'(0), "R9 pin released stand-alone");
        strap_run = 1'b0;
        wait_n(4);
        check(cfg_o, DEF_PDN, "R6 default image power-down");
        check(72'(pdn_o), 72'(1), "R6 pdn with run low");
        strap_run = 1'b1;
        wait_n(4);

        // Table walk: load, release strap, compare bank (R2 R3 R5 R8), tail (R4), pin (R9).
        prev = '0;
        for (int e = 0; e < 4; e++) begin
            strap_alone = 1'b1;
            wait_n(4);
            load_image(STIM[e], prev, miss);
            if (e > 0) check(72'(miss), 72'(0), "R4 old image on tail");
            strap_alone = 1'b0;
            wait_n(4);
            check(cfg_o, EXPV[e], "R3 loaded bank");
            check(72'(vox_o), 72'(EXPV[e][71]), "R4 tail equals R8 bit 7");
            check(72'(hpdn_drive_o), 72'(EXPV[e][41]), "R9 pin value from R5 bit 1");
            check(72'(tone_en_o), 72'(1), "R7 tone permitted bus mode");
            prev = EXPV[e];
        end

        // R10: edges with run strap low do nothing.
        snap = cfg_o;
        strap_alone = 1'b1; strap_run = 1'b0;
        wait_n(4);
        for (int j = 0; j < 10; j++) begin
            ser_dat = ~ser_dat;
            wait_n(4); ser_clk = 1'b1; wait_n(4); ser_clk = 1'b0; wait_n(4);
        end
        strap_alone = 1'b0; strap_run = 1'b1;
        wait_n(4);
        check(cfg_o, snap, "R10 no shift with run low");

        // R1: a rising edge alone does not shift; falling edge in bus mode neither.
        strap_alone = 1'b1; ser_dat = 1'b1;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(4);
        strap_alone = 1'b0;
        wait_n(4);
        ser_clk = 1'b0;
        wait_n(4);
        check(cfg_o, snap, "R1 rising edge and bus-mode edge ignored");

        // R8: bus writes.
        bus_write(4'd0, 8'hFF);
        check(72'(cfg_o[7:0]), 72'h3F, "R8 R5 write R0 upper bits dropped");
        bus_write(4'd7, 8'h5A);
        check(72'(cfg_o[63:56]), 72'h5A, "R8 write R7");
        snap = cfg_o;
        bus_write(4'd12, 8'hFF);
        check(cfg_o, snap, "R8 out-of-range write ignored");
        strap_alone = 1'b1;
        wait_n(4);
        bus_write(4'd2, 8'h77);
        strap_alone = 1'b0;
        wait_n(4);
        check(cfg_o, snap, "R8 write ignored stand-alone");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule